// File: doc/BRIEF.md
# ECC Error Capture Log

This block keeps a record of the first memory ECC error seen on one DRAM channel. Each read burst carries four quadword beats. For each beat the ECC decoder reports, with a valid strobe, whether the data was corrected (single-bit) or could not be corrected (multi-bit), along with an 8-bit syndrome. The rank, bank, row and column of the burst come with these reports. All four beats of a cycle are evaluated together. A fixed priority picks one beat. Its syndrome and the burst address are stored into a 64-bit read-only log word.

The log holds the first error only. Later errors of the same or lower severity leave it alone. An uncorrectable error still replaces a logged correctable entry, and after that nothing changes the log. Software releases the log with two single-cycle clear pulses, one for each status flag. The log takes new errors again only when neither flag remains set. The stored fields keep their values until the next capture.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, and after any later reset, every bit of `log_word` reads zero and both status flags are clear.
- R2: `log_word` packs the column in bits 63:48, row in 47:32, bank in 31:29, rank in 28:27 and syndrome in 23:16. Bit 1 is the uncorrectable flag and bit 0 is the correctable flag. Bits 26:24 and 15:2 read as zero.
- R3: A quadword's correctable or uncorrectable flag counts only in a cycle where its bit of `qw_vld` is high. Otherwise it has no effect. The syndrome of quadword i is `qw_synd[8*i+7:8*i]`.
- R4: When several quadwords report errors together, the logged one is chosen in this order: uncorrectable on quadword 0, 1, 2, 3, then correctable on quadword 0, 1, 2, 3. A quadword that reports both flags counts as uncorrectable.
- R5: A correctable error that arrives while neither flag is set is captured and sets bit 0. While bit 0 stays set, further correctable errors change nothing.
- R6: An uncorrectable error that arrives while bit 1 is clear is captured, even over a logged correctable entry, and sets bit 1. A correctable flag that is already set stays set.
- R7: While bit 1 is set, no error of either kind changes the log word.
- R8: `clr_ce` clears bit 0 and `clr_ue` clears bit 1. Clearing does not erase the stored fields. A correctable error is captured again only once both flags are clear.
- R9: A clear and an error in the same cycle act as if the clear came first. The error is then judged against the remaining flags and may be captured as a new first error.
- R10: A capture and any flag change show on `log_word` one clock edge after the cycle in which the inputs were presented, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| qw_vld | input | NUM_QW | Per-quadword report valid strobe |
| qw_ce | input | NUM_QW | Per-quadword correctable error flag |
| qw_ue | input | NUM_QW | Per-quadword uncorrectable error flag |
| qw_synd | input | NUM_QW*8 | Per-quadword syndromes, quadword i in bits 8i+7:8i |
| rd_rank | input | 2 | Rank of the burst |
| rd_bank | input | 3 | Bank of the burst |
| rd_row | input | 16 | Row of the burst |
| rd_col | input | 16 | Column of the burst |
| clr_ce | input | 1 | Software clear pulse for the correctable flag |
| clr_ue | input | 1 | Software clear pulse for the uncorrectable flag |
| log_word | output | 64 | Read-only log word |
| ce_sts | output | 1 | Correctable error flag |
| ue_sts | output | 1 | Uncorrectable error flag |

## Verification
The assertions treat a quadword flag as meaningful only when its valid strobe is high. They treat a clear as a pulse that is judged together with any error in the same cycle. They assume address and syndrome inputs carry no meaning outside a valid report. The stimulus changes inputs only on the falling edge and keeps each clear high for exactly one cycle. Each row uses its own address and syndrome values, so any capture at the wrong time or of the wrong quadword shows up as a different log word.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int SYND_W   = 8;
  localparam int COL_W    = 16;
  localparam int ROW_W    = 16;
  localparam int BANK_W   = 3;
  localparam int RANK_W   = 2;
  localparam int LOG_W    = 64;
  localparam int COL_LSB  = 48;
  localparam int ROW_LSB  = 32;
  localparam int BANK_LSB = 29;
  localparam int RANK_LSB = 27;
  localparam int SYND_LSB = 16;
  localparam int UE_BIT   = 1;
  localparam int CE_BIT   = 0;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } err_entry_t;
endpackage

// File: rtl/ecc_qw_select.sv
module ecc_qw_select import ecc_log_pkg::*; #(
  parameter int NUM_QW = 4
) (
  input  logic [NUM_QW-1:0]        qw_vld,
  input  logic [NUM_QW-1:0]        qw_ce,
  input  logic [NUM_QW-1:0]        qw_ue,
  input  logic [NUM_QW*SYND_W-1:0] qw_synd,
  output logic                     ue_hit,
  output logic                     ce_hit,
  output logic [SYND_W-1:0]        sel_synd
);
  localparam int IDX_W = (NUM_QW > 1) ? $clog2(NUM_QW) : 1;

  logic [NUM_QW-1:0] ue_q;
  logic [NUM_QW-1:0] ce_q;
  logic [SYND_W-1:0] synd_arr [NUM_QW];
  logic [IDX_W-1:0]  ue_idx;
  logic [IDX_W-1:0]  ce_idx;
  logic [IDX_W-1:0]  sel_idx;

  // gate each beat by its strobe; a beat with both flags counts as uncorrectable
  for (genvar g = 0; g < NUM_QW; g++) begin : g_beat
    assign ue_q[g]     = qw_vld[g] & qw_ue[g];
    assign ce_q[g]     = qw_vld[g] & qw_ce[g] & ~qw_ue[g];
    assign synd_arr[g] = qw_synd[g*SYND_W +: SYND_W];
  end

  // lowest beat index wins within each severity
  always_comb begin
    ue_idx = '0;
    ce_idx = '0;
    for (int i = NUM_QW - 1; i >= 0; i--) begin
      if (ue_q[i]) ue_idx = IDX_W'(i);
      if (ce_q[i]) ce_idx = IDX_W'(i);
    end
  end

  assign ue_hit   = |ue_q;
  assign ce_hit   = |ce_q;
  assign sel_idx  = ue_hit ? ue_idx : ce_idx;
  assign sel_synd = synd_arr[sel_idx];
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ue_hit,
  input  logic ce_hit,
  input  logic clr_ce,
  input  logic clr_ue,
  output logic ce_sts,
  output logic ue_sts,
  output logic cap_en
);
  logic ce_q, ue_q;
  logic ce_d, ue_d;
  logic ce_keep, ue_keep;
  logic cap_ue, cap_ce;

  // clears are applied before the errors of the same cycle are judged
  always_comb begin
    ce_keep = ce_q & ~clr_ce;
    ue_keep = ue_q & ~clr_ue;
    cap_ue  = ue_hit & ~ue_keep;
    cap_ce  = ce_hit & ~ue_hit & ~ue_keep & ~ce_keep;
    ue_d    = ue_keep | cap_ue;
    ce_d    = ce_keep | cap_ce;
    cap_en  = cap_ue | cap_ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      ue_q <= 1'b0;
    end else begin
      ce_q <= ce_d;
      ue_q <= ue_d;
    end
  end

  assign ce_sts = ce_q;
  assign ue_sts = ue_q;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log import ecc_log_pkg::*; #(
  parameter int NUM_QW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_QW-1:0]        qw_vld,
  input  logic [NUM_QW-1:0]        qw_ce,
  input  logic [NUM_QW-1:0]        qw_ue,
  input  logic [NUM_QW*SYND_W-1:0] qw_synd,
  input  logic [RANK_W-1:0]        rd_rank,
  input  logic [BANK_W-1:0]        rd_bank,
  input  logic [ROW_W-1:0]         rd_row,
  input  logic [COL_W-1:0]         rd_col,
  input  logic                     clr_ce,
  input  logic                     clr_ue,
  output logic [LOG_W-1:0]         log_word,
  output logic                     ce_sts,
  output logic                     ue_sts
);
  logic              ue_hit, ce_hit, cap_en;
  logic [SYND_W-1:0] sel_synd;
  err_entry_t        ent_q, ent_d, ent_new;

  ecc_qw_select #(.NUM_QW(NUM_QW)) u_sel (
    .qw_vld  (qw_vld),
    .qw_ce   (qw_ce),
    .qw_ue   (qw_ue),
    .qw_synd (qw_synd),
    .ue_hit  (ue_hit),
    .ce_hit  (ce_hit),
    .sel_synd(sel_synd)
  );

  ecc_log_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .ue_hit(ue_hit),
    .ce_hit(ce_hit),
    .clr_ce(clr_ce),
    .clr_ue(clr_ue),
    .ce_sts(ce_sts),
    .ue_sts(ue_sts),
    .cap_en(cap_en)
  );

  always_comb begin
    ent_new.col  = rd_col;
    ent_new.row  = rd_row;
    ent_new.bank = rd_bank;
    ent_new.rank = rd_rank;
    ent_new.synd = sel_synd;
    ent_d        = cap_en ? ent_new : ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= '0;
    else        ent_q <= ent_d;
  end

  always_comb begin
    log_word = '0;
    log_word[COL_LSB  +: COL_W]  = ent_q.col;
    log_word[ROW_LSB  +: ROW_W]  = ent_q.row;
    log_word[BANK_LSB +: BANK_W] = ent_q.bank;
    log_word[RANK_LSB +: RANK_W] = ent_q.rank;
    log_word[SYND_LSB +: SYND_W] = ent_q.synd;
    log_word[UE_BIT]             = ue_sts;
    log_word[CE_BIT]             = ce_sts;
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int NUM_QW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_QW-1:0] qw_vld,
  input logic [NUM_QW-1:0] qw_ce,
  input logic [NUM_QW-1:0] qw_ue,
  input logic              clr_ce,
  input logic              clr_ue,
  input logic [63:0]       log_word
);
  logic any_ue, any_ce;
  assign any_ue = |(qw_vld & qw_ue);
  assign any_ce = |(qw_vld & qw_ce);

  AST_UE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_ue |=> log_word[1]); // R6
  AST_UE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (log_word[1] && !clr_ue) |=> (log_word[1] && $stable(log_word[63:16]))); // R7
  AST_CE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (log_word[0] && !clr_ce && !any_ue) |=> $stable(log_word[63:16])); // R5
  AST_CE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_word[0] && !log_word[1] && any_ce && !any_ue) |=> log_word[0]); // R5
  AST_CLR_UE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && !any_ue) |=> !log_word[1]); // R8
  AST_CLR_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !any_ce) |=> !log_word[0]); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ue && !any_ce && !clr_ce && !clr_ue) |=> $stable(log_word)); // R10
endmodule

bind ecc_err_log ecc_err_log_chk #(.NUM_QW(NUM_QW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .qw_vld  (qw_vld),
  .qw_ce   (qw_ce),
  .qw_ue   (qw_ue),
  .clr_ce  (clr_ce),
  .clr_ue  (clr_ue),
  .log_word(log_word)
);

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  qw_vld, qw_ce, qw_ue;
  logic [31:0] qw_synd;
  logic [1:0]  rd_rank;
  logic [2:0]  rd_bank;
  logic [15:0] rd_row, rd_col;
  logic        clr_ce, clr_ue;
  logic [63:0] log_word;
  logic        ce_sts, ue_sts;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .qw_vld(qw_vld), .qw_ce(qw_ce), .qw_ue(qw_ue),
    .qw_synd(qw_synd), .rd_rank(rd_rank), .rd_bank(rd_bank), .rd_row(rd_row),
    .rd_col(rd_col), .clr_ce(clr_ce), .clr_ue(clr_ue), .log_word(log_word),
    .ce_sts(ce_sts), .ue_sts(ue_sts)
  );

  typedef struct packed {
    logic [3:0] vld;
    logic [3:0] ce;
    logic [3:0] ue;
    logic       cc;
    logic       cu;
    logic       ece;
    logic       eue;
    logic [7:0] src;   // row whose address is expected in the log, FF = none
    logic [1:0] qw;    // beat whose syndrome is expected
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'd0},
    '{4'h0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'd0},
    '{4'hC, 4'hC, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2,  2'd2},
    '{4'hF, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2,  2'd2},
    '{4'hF, 4'h1, 4'hA, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4,  2'd1},
    '{4'hF, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4,  2'd1},
    '{4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4,  2'd1},
    '{4'hF, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4,  2'd1},
    '{4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  2'd1},
    '{4'hF, 4'h7, 4'h8, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9,  2'd3},
    '{4'hF, 4'h2, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 2'd1},
    '{4'h4, 4'h0, 4'h4, 1'b1, 1'b0, 1'b0, 1'b1, 8'd11, 2'd2},
    '{4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd11, 2'd2},
    '{4'hB, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd13, 2'd0},
    '{4'hF, 4'h8, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd14, 2'd3},
    '{4'hF, 4'h0, 4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd15, 2'd0},
    '{4'hF, 4'h1, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd16, 2'd0}
  };

  function automatic string tag_of(int k);
    case (k)
      1:            return "R3";
      2:            return "R2";
      3:            return "R5";
      4, 15:        return "R6";
      5:            return "R7";
      6, 7, 8, 12:  return "R8";
      9, 13, 16:    return "R4";
      10, 11, 14:   return "R9";
      default:      return "R10";
    endcase
  endfunction

  function automatic logic [7:0] synd_of(int k, int i);
    return {4'(k), 2'b10, 2'(i)};
  endfunction

  function automatic logic [63:0] exp_word(logic [7:0] src, logic [1:0] qw,
                                           logic ece, logic eue);
    logic [63:0] w;
    w = '0;
    if (src != 8'hFF) begin
      w[63:48] = 16'hC000 + 16'(src);
      w[47:32] = 16'h5A00 + 16'(src);
      w[31:29] = 3'(src);
      w[28:27] = 2'(src + 8'd1);
      w[23:16] = synd_of(int'(src), int'(qw));
    end
    w[1] = eue;
    w[0] = ece;
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: log_word actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    qw_vld = '0; qw_ce = '0; qw_ue = '0; qw_synd = '0;
    rd_rank = '0; rd_bank = '0; rd_row = '0; rd_col = '0;
    clr_ce = 1'b0; clr_ue = 1'b0;
  endtask

  task automatic drive_row(int k, vec_t v);
    qw_vld = v.vld; qw_ce = v.ce; qw_ue = v.ue;
    for (int i = 0; i < 4; i++) qw_synd[i*8 +: 8] = synd_of(k, i);
    rd_col  = 16'hC000 + 16'(k);
    rd_row  = 16'h5A00 + 16'(k);
    rd_bank = 3'(k);
    rd_rank = 2'(k + 1);
    clr_ce  = v.cc;
    clr_ue  = v.cu;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    #1;
    check("R1", log_word, 64'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", log_word, 64'h0);

    // table walk: drive on the falling edge, sample 1 ns after the rising edge
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive_row(k, VECS[k]);
      @(posedge clk);
      #1;
      check(tag_of(k),
            log_word,
            exp_word(VECS[k].src, VECS[k].qw, VECS[k].ece, VECS[k].eue));
    end

    // R1: reset in mid-run wipes a populated log
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    #1;
    check("R1", log_word, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: nothing visible before the capturing edge, visible right after it
    @(negedge clk);
    drive_row(20, '{4'h2, 4'h2, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd20, 2'd1});
    #1;
    check("R10", log_word, 64'h0);
    @(posedge clk);
    #1;
    check("R10", log_word, exp_word(8'd20, 2'd1, 1'b1, 1'b0));
    @(negedge clk);
    drive_idle();
    @(posedge clk);
    #1;
    check("R10", log_word, exp_word(8'd20, 2'd1, 1'b1, 1'b0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule